// File: doc/BRIEF.md
# Multi-Channel Event Timer with Write-Sync Tracking

This block is a register-mapped event timer. A 64-bit main counter advances by one per clock while a global enable is set. Three compare channels watch it. Channel 0 compares the full 64 bits. Channels 1 and 2 compare only the low 32 bits, so they match once on every wrap of the low word.

A match sets the channel's bit in an interrupt status word. Each channel drives one interrupt line, gated by that channel's enable.

Software reaches the block over a 32-bit request bus made of `req_valid`, `req_write`, `req_addr`, `req_wdata`, `req_ready` and `rd_data`. The block models a slow timer domain, so a write lands a fixed `SYNC_DELAY` cycles after it is accepted. While a write is pending, a busy flag for that register is visible in a sync-status word.

Back-pressure rules:
- A transfer happens on a clock edge where both `req_valid` and `req_ready` are high.
- A write to a register whose previous write is still pending sees `req_ready` low until that earlier write has landed. The requester must hold the request stable meanwhile.
- A read is always ready. `rd_data` shows the addressed register combinationally.
- A write to an unmapped address is accepted and dropped.

Top module: `evt_timer_top`

## Requirements
- R1: Reset clears the counter. The counter then increments by one per cycle while bit 0 of the global config register (0x010) is 1, and holds while that bit is 0.
- R2: The counter low word is at 0x0F0 and the high word at 0x0F4. Each is readable and writable, and a write replaces only the addressed half.
- R3: The sync-status word at 0x200 has one busy bit per register: bit 0 global config, bit 1 interrupt status, bit 2 counter, bits 3..5 channel 0..2 config, bits 6..8 channel 0..2 comparator. A busy bit reads 1 on the `SYNC_DELAY` cycles after the accepting edge. The register takes its new value on the edge where the busy bit falls.
- R4: A write to a register whose busy bit is set sees `req_ready` low, while writes to other registers and all reads see it high.
- R5: Bit 12 of the sync-status word reads 1 exactly while a counter write is pending.
- R6: The channel 0 comparator is 64 bits, with the low word at 0x108 and the high word at 0x10C. Status bit 0 sets on the edge after the enabled counter equals it, so when the interrupt first shows, the counter reads the comparator plus one.
- R7: The channel 1 comparator (0x128) and the channel 2 comparator (0x148) are 32 bits and compare against the counter low word only, including across a wrap of that low word.
- R8: The interrupt status word at 0x020 holds bit n for channel n. Writing 1 to a bit clears it after the sync delay, and writing 0 leaves it unchanged.
- R9: The channel config registers are at 0x100, 0x120 and 0x140. Bit 0 is the interrupt enable, bit 1 is the trigger type (1 = level), and bits 8:4 are a 5-bit route field that is stored and read back. In level mode `irq[n]` is high exactly while both the enable bit and status bit n are set.
- R10: In pulse mode (trigger type 0), `irq[n]` is high for one cycle, on the cycle after a match that sets status bit n from 0.
- R11: Reset loads every comparator with all ones, and clears the status bits, the configs and all busy bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rd_data | output | 32 | Read data for req_addr |
| irq | output | 3 | One interrupt line per channel |

## Verification
A wrong busy counter shows up on the first write after it goes wrong. The busy bit at 0x200 falls on the wrong cycle, the register value changes a cycle off from that fall, or `req_ready` stalls a write that should pass.

A miscompared channel shows up on the cycle after the intended match. The counter value read at the interrupt's first cycle is not the comparator plus one. A channel 1 or 2 that compares on 64 bits never fires after a low-word wrap.

A status bit that is stuck or clears wrongly shows up as a level interrupt that stays high or drops out of step with the clearing write's sync delay.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int NCH   = 3;
  localparam int NSLOT = 3 + 2 * NCH;

  // busy-slot indices; their order is the bit order of the sync-status word
  localparam int SL_GCFG = 0;
  localparam int SL_ISR  = 1;
  localparam int SL_CNT  = 2;
  localparam int SL_CFG0 = 3;
  localparam int SL_CMP0 = 3 + NCH;
  localparam int INVALID_BIT = 12;

  localparam logic [11:0] A_GCFG  = 12'h010;
  localparam logic [11:0] A_ISR   = 12'h020;
  localparam logic [11:0] A_CNTLO = 12'h0F0;
  localparam logic [11:0] A_CNTHI = 12'h0F4;
  localparam logic [11:0] A_CHBASE = 12'h100;
  localparam logic [11:0] A_CHSTEP = 12'h020;
  localparam logic [11:0] A_CMPOFS = 12'h008;
  localparam logic [11:0] A_SYNC  = 12'h200;

  typedef struct packed {
    logic [4:0] route;
    logic       level;
    logic       ie;
  } chan_cfg_t;

  function automatic logic [31:0] cfg_to_word(chan_cfg_t c);
    return {23'b0, c.route, 2'b00, c.level, c.ie};
  endfunction

  function automatic chan_cfg_t word_to_cfg(logic [31:0] w);
    chan_cfg_t c;
    c.route = w[8:4];
    c.level = w[1];
    c.ie    = w[0];
    return c;
  endfunction
endpackage

// File: rtl/evt_sync_slot.sv
module evt_sync_slot #(
  parameter int DELAY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] din,
  input  logic        din_hi,
  output logic        busy,
  output logic        fire,
  output logic [31:0] dout,
  output logic        dout_hi
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left    <= '0;
      dout    <= '0;
      dout_hi <= 1'b0;
    end else if (load) begin
      left    <= CW'(DELAY);
      dout    <= din;
      dout_hi <= din_hi;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);
  assign fire = (left == CW'(1));

  assert_busy_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  assert_fire_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy);
  assert_no_load_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr_fire,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  output logic [CNT_W-1:0] cnt
);
  localparam int HALF = CNT_W / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_fire) begin
      if (wr_hi) cnt[CNT_W-1:HALF] <= wr_data[HALF-1:0];
      else       cnt[HALF-1:0]     <= wr_data[HALF-1:0];
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_fire) |=> cnt == $past(cnt) + 1'b1);
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_fire) |=> $stable(cnt));
endmodule

// File: rtl/evt_cmp_chan.sv
module evt_cmp_chan
  import evt_timer_pkg::*;
#(
  parameter bit WIDE  = 1'b0,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run,
  input  logic             cfg_fire,
  input  logic [31:0]      cfg_din,
  input  logic             cmp_fire,
  input  logic             cmp_hi,
  input  logic [31:0]      cmp_din,
  input  logic             clr_fire,
  input  logic             clr_bit,
  output logic [31:0]      cfg_word,
  output logic [31:0]      cmp_lo_q,
  output logic [31:0]      cmp_hi_q,
  output logic             status,
  output logic             irq
);
  chan_cfg_t cfg;
  logic      match;
  logic      hit;
  logic      pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_lo_q <= '1;
    end else if (cmp_fire && !cmp_hi) begin
      cmp_lo_q <= cmp_din;
    end
  end

  generate
    if (WIDE) begin : g_wide
      always_ff @(posedge clk) begin
        if (!rst_n)                  cmp_hi_q <= '1;
        else if (cmp_fire && cmp_hi) cmp_hi_q <= cmp_din;
      end
      assign match = (cnt == {cmp_hi_q, cmp_lo_q});
    end else begin : g_narrow
      assign cmp_hi_q = '0;
      assign match    = (cnt[31:0] == cmp_lo_q);
    end
  endgenerate

  assign hit = run && match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      status  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (cfg_fire) cfg <= word_to_cfg(cfg_din);
      status  <= (status & ~(clr_fire & clr_bit)) | hit;
      pulse_q <= hit & ~status;
    end
  end

  assign cfg_word = cfg_to_word(cfg);
  assign irq      = cfg.ie & (cfg.level ? status : pulse_q);

  assert_hit_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> status);
  assert_status_clear_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> $past(clr_fire && clr_bit));
  assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg.level && !cfg_fire) |=> !irq);
endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int SYNC_DELAY = 3,
  parameter int AW         = 12,
  parameter int CNT_W      = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic [31:0]   rd_data,
  output logic [NCH-1:0] irq
);
  logic [NSLOT-1:0] sel, busy, fire, load;
  logic [31:0]      sdata [NSLOT];
  logic [NSLOT-1:0] shi;
  logic             wr_req, gen_en;
  logic [CNT_W-1:0] cnt;
  logic [NCH-1:0]   status;
  logic [31:0]      cfg_w [NCH];
  logic [31:0]      cmp_lo [NCH];
  logic [31:0]      cmp_hi [NCH];
  logic [11:0]      a12;

  assign a12    = 12'(req_addr);
  assign wr_req = req_valid && req_write;

  always_comb begin
    sel = '0;
    sel[SL_GCFG] = (a12 == A_GCFG);
    sel[SL_ISR]  = (a12 == A_ISR);
    sel[SL_CNT]  = (a12 == A_CNTLO) || (a12 == A_CNTHI);
    for (int i = 0; i < NCH; i++) begin
      sel[SL_CFG0+i] = (a12 == A_CHBASE + 12'(i) * A_CHSTEP);
      sel[SL_CMP0+i] = (a12 == A_CHBASE + 12'(i) * A_CHSTEP + A_CMPOFS) ||
                       (i == 0 && a12 == A_CHBASE + A_CMPOFS + 12'h004);
    end
  end

  assign req_ready = !(wr_req && |(sel & busy));
  assign load      = (wr_req && req_ready) ? sel : '0;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      evt_sync_slot #(.DELAY(SYNC_DELAY)) u_slot (
        .clk(clk), .rst_n(rst_n), .load(load[s]), .din(req_wdata),
        .din_hi(a12[2]), .busy(busy[s]), .fire(fire[s]),
        .dout(sdata[s]), .dout_hi(shi[s])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)              gen_en <= 1'b0;
    else if (fire[SL_GCFG])  gen_en <= sdata[SL_GCFG][0];
  end

  evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(gen_en), .wr_fire(fire[SL_CNT]),
    .wr_hi(shi[SL_CNT]), .wr_data(sdata[SL_CNT]), .cnt(cnt)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chan
      evt_cmp_chan #(.WIDE(c == 0), .CNT_W(CNT_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .run(gen_en),
        .cfg_fire(fire[SL_CFG0+c]), .cfg_din(sdata[SL_CFG0+c]),
        .cmp_fire(fire[SL_CMP0+c]), .cmp_hi(shi[SL_CMP0+c]),
        .cmp_din(sdata[SL_CMP0+c]),
        .clr_fire(fire[SL_ISR]), .clr_bit(sdata[SL_ISR][c]),
        .cfg_word(cfg_w[c]), .cmp_lo_q(cmp_lo[c]), .cmp_hi_q(cmp_hi[c]),
        .status(status[c]), .irq(irq[c])
      );
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (a12 == A_GCFG)       rd_data = {31'b0, gen_en};
    else if (a12 == A_ISR)   rd_data = 32'(status);
    else if (a12 == A_CNTLO) rd_data = cnt[31:0];
    else if (a12 == A_CNTHI) rd_data = cnt[CNT_W-1:32];
    else if (a12 == A_SYNC) begin
      rd_data = 32'(busy);
      rd_data[INVALID_BIT] = busy[SL_CNT];
    end
    for (int i = 0; i < NCH; i++) begin
      if (a12 == A_CHBASE + 12'(i) * A_CHSTEP) rd_data = cfg_w[i];
      if (a12 == A_CHBASE + 12'(i) * A_CHSTEP + A_CMPOFS) rd_data = cmp_lo[i];
      if (i == 0 && a12 == A_CHBASE + A_CMPOFS + 12'h004) rd_data = cmp_hi[i];
    end
  end

  assert_read_always_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> req_ready);
  assert_cnt_write_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load[SL_CNT] |=> busy[SL_CNT]);
  assert_disabled_no_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !fire[SL_ISR]) |=> $stable(status));
endmodule

// File: tb/evt_timer_top_test.sv
module evt_timer_top_test;
  localparam int DLY = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rd_data;
  logic [2:0]  irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evt_timer_top #(.SYNC_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [31:0] exp_cfg(logic [31:0] w);
    return w & 32'h0000_01F3;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    req_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic settle();
    repeat (DLY + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, lo, hi;
    int seen;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 / R1 reset state
    peek(12'h0F0, v); chk("R1 reset counter", v, 0);
    peek(12'h200, v); chk("R11 busy clear", v, 0);
    peek(12'h020, v); chk("R11 status clear", v, 0);
    peek(12'h108, v); chk("R11 cmp0 lo ones", v, 32'hFFFF_FFFF);
    peek(12'h10C, v); chk("R11 cmp0 hi ones", v, 32'hFFFF_FFFF);
    peek(12'h148, v); chk("R11 cmp2 ones", v, 32'hFFFF_FFFF);
    chk("R11 irq low", irq, 0);
    repeat (5) @(negedge clk);
    peek(12'h0F0, v); chk("R1 held while disabled", v, 0);

    // R3 busy timing on channel 1 comparator
    wr(12'h128, 32'h1234_5678);
    for (int k = 0; k < DLY; k++) begin
      @(negedge clk);
      peek(12'h200, v); chk("R3 busy bit7 set", v[7], 1'b1);
      peek(12'h128, v); chk("R3 value not yet", v, 32'hFFFF_FFFF);
    end
    @(negedge clk);
    peek(12'h200, v); chk("R3 busy bit7 clear", v[7], 1'b0);
    peek(12'h128, v); chk("R3 value landed", v, 32'h1234_5678);

    // R4 stall on same register, pass on other
    wr(12'h100, 32'h0000_0012);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h100; req_wdata = 32'h0;
    #1; chk("R4 same reg stalls", req_ready, 1'b0);
    req_addr = 12'h140; #1; chk("R4 other reg ready", req_ready, 1'b1);
    req_write = 1'b0; req_addr = 12'h100; #1; chk("R4 read ready", req_ready, 1'b1);
    req_valid = 1'b0;
    settle();

    // R2 / R5 counter write with invalid flag
    wr(12'h0F0, 32'h0000_0100);
    @(negedge clk);
    peek(12'h200, v); chk("R5 invalid set", v[12], 1'b1);
    chk("R3 counter busy", v[2], 1'b1);
    settle();
    peek(12'h200, v); chk("R5 invalid clear", v[12], 1'b0);
    peek(12'h0F0, v); chk("R2 counter lo written", v, 32'h100);
    peek(12'h0F4, v); chk("R2 counter hi kept", v, 0);

    // random readback (counter stopped)
    for (int n = 0; n < 24; n++) begin
      logic [31:0] d;
      logic [11:0] a;
      int pick = $urandom_range(0, 3);
      d = $urandom();
      a = (pick == 0) ? 12'h0F4 : (pick == 1) ? 12'h148 :
          (pick == 2) ? 12'h120 : 12'h10C;
      wr(a, d);
      settle();
      peek(a, v);
      if (pick == 2) chk("R9 cfg route readback", v, exp_cfg(d));
      else if (pick == 0) chk("R2 counter hi readback", v, d);
      else chk("R7 cmp readback", v, d);
    end
    wr(12'h120, 32'h0);

    // R6 channel 0 64-bit match, level irq
    wr(12'h0F0, 32'h0000_0040);
    wr(12'h0F4, 32'h0000_0000);
    wr(12'h108, 32'h0000_0054);
    wr(12'h10C, 32'h0000_0000);
    wr(12'h100, 32'h0000_0003);
    settle();
    chk("R9 no irq before match", irq, 0);
    wr(12'h010, 32'h1);
    seen = 0;
    for (int t = 0; t < 200 && !seen; t++) begin
      @(negedge clk);
      if (irq[0]) begin
        seen = 1;
        peek(12'h0F0, lo);
        chk("R6 counter at irq", lo, 32'h55);
      end
    end
    chk("R6 irq0 raised", seen, 1);
    peek(12'h020, v); chk("R6 status bit0", v, 32'h1);

    // R8 write-0 no effect, write-1 clears after delay
    wr(12'h020, 32'h0);
    settle();
    chk("R8 write 0 keeps", irq[0], 1'b1);
    wr(12'h020, 32'h1);
    for (int k = 0; k < DLY; k++) begin
      @(negedge clk);
      chk("R8 still set during sync", irq[0], 1'b1);
    end
    @(negedge clk);
    chk("R8 cleared", irq[0], 1'b0);
    peek(12'h020, v); chk("R8 status clear", v, 0);

    // R7 / R10 wrap of low word
    wr(12'h010, 32'h0);
    wr(12'h0F0, 32'hFFFF_FFF0);
    wr(12'h0F4, 32'h0000_0005);
    wr(12'h128, 32'h0000_0004);
    wr(12'h120, 32'h0000_0003);
    wr(12'h148, 32'h0000_0002);
    wr(12'h140, 32'h0000_0001);
    settle();
    wr(12'h010, 32'h1);
    seen = 0;
    for (int t = 0; t < 200 && seen < 2; t++) begin
      @(negedge clk);
      if (irq[2] && seen == 0) begin
        peek(12'h0F0, lo);
        chk("R10 pulse at cmp+1", lo, 32'h3);
        @(negedge clk);
        chk("R10 pulse one cycle", irq[2], 1'b0);
        seen = 1;
      end
      if (irq[1] && seen == 1) begin
        peek(12'h0F0, lo); peek(12'h0F4, hi);
        chk("R7 ch1 low word", lo, 32'h5);
        chk("R7 ch1 after wrap", hi, 32'h6);
        seen = 2;
      end
    end
    chk("R7 both fired", seen, 2);
    peek(12'h020, v); chk("R10 status kept", v, 32'h6);

    // R9 enable gates the level line
    wr(12'h120, 32'h0000_0002);
    settle();
    chk("R9 ie off masks irq", irq[1], 1'b0);
    peek(12'h020, v); chk("R9 status still set", v[1], 1'b1);
    wr(12'h120, 32'h0000_0003);
    settle();
    chk("R9 ie on shows irq", irq[1], 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule